// File: doc/BRIEF.md
# VRAM Block DMA Controller

This controller moves data from the CPU address space into an 8 KiB video RAM window in units of 16-byte blocks. Software loads a source pointer and a destination pointer through a small register write port. It then writes a control byte that gives the block count and the mode. In general mode the engine copies every block in one burst and holds the CPU stalled for the whole run. In blank-period mode it copies one block for each pulse it receives from the display timing, and it parks between pulses.

The engine has four states. `ST_IDLE` waits for a control write. `ST_PARK` waits in blank-period mode for the next blank pulse. `ST_LEAD` is a fixed four-tick start delay. `ST_MOVE` moves bytes: it reads in the first tick of each byte slot and writes in the last.

The transitions are:
- IDLE→LEAD on a control write with the mode bit clear.
- IDLE→PARK on a control write with the mode bit set.
- PARK→LEAD on a blank pulse.
- LEAD→MOVE when the delay expires.
- MOVE→PARK at the end of a block in blank-period mode when blocks remain.
- MOVE→IDLE at the end of the final block.

Some sources cannot be fetched. For those the byte stored is an open-bus value: the CPU's last fetched opcode for the first byte of a run, and 0xFF otherwise.

Top module: `vram_block_dma`

## Requirements
- R1: After reset and whenever no transfer is active, `ctl_rdata` reads 0xFF, `cpu_stall` is low and neither `mem_re` nor `mem_we` is asserted. A blank pulse while idle starts nothing.
- R2: Register select 2 (destination high) keeps only bits 4:0 of the written byte as pointer bits 12:8. Select 3 (destination low) keeps bits 7:4 of the written byte, and pointer bits 3:0 become zero. Every write goes to address 0x8000 OR the low 13 bits of the running destination pointer, so a run past 0x9FFF continues at 0x8000.
- R3: Register select 0 (source high) sets source bits 15:8. If the result is at or above 0xE000, bits 15:12 are forced to 0xF. Select 1 (source low) keeps bits 7:4, and source bits 3:0 become zero.
- R4: A source byte is fetched from memory, with `mem_re` asserted, only when the source address is below 0x8000 or lies in 0xA000–0xDFFF. For any other source no read is issued and the open-bus value is written instead.
- R5: The open-bus value is the `cpu_opcode` byte sampled when the run starts, for the first byte of each run. It is 0xFF for every later byte of that run. It is also 0xFF for the first byte when `cpu_pc` is above 0x8000 at the start. In blank-period mode each block is a separate run.
- R6: Each run begins with 4 stall cycles that carry no memory access. Each byte then takes 2 cycles, or 4 cycles when `double_speed` was high at the run's start. The read comes in the first cycle of the slot and the write in the last. `cpu_stall` is high exactly during these delay and byte cycles.
- R7: In general mode (control bit 7 = 0) all blocks are copied back to back after a single start delay.
- R8: In blank-period mode (control bit 7 = 1) the engine copies one block after each `hblank_pulse`, then parks with `cpu_stall` low. A pulse that arrives while a block is being copied is ignored.
- R9: While a transfer is active, `ctl_rdata` reads bit 7 = 0 and bits 6:0 = remaining blocks minus one. After the last block it returns to 0xFF.
- R10: Register writes of any select are ignored while a transfer is active, including while the engine is parked.
- R11: The control byte's bits 6:0 hold the block count minus one, giving 1 to 128 blocks. The remaining count drops when the destination pointer's low four bits roll over to zero, and a run writes exactly 16 bytes per block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock (one cycle per 8 MHz tick) |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 src high, 1 src low, 2 dst high, 3 dst low, 4 control |
| reg_wdata | input | 8 | Register write data |
| ctl_rdata | output | 8 | Control readback: {idle, remaining blocks − 1} |
| hblank_pulse | input | 1 | One-cycle blank-period pulse from display timing |
| double_speed | input | 1 | High selects 4 cycles per byte |
| cpu_opcode | input | 8 | Last opcode byte fetched by the CPU |
| cpu_pc | input | 16 | CPU program counter |
| cpu_stall | output | 1 | Stalls the CPU while bytes are being moved |
| mem_addr | output | 16 | Memory address (source on read, VRAM on write) |
| mem_re | output | 1 | Memory read strobe; data returned in the same cycle |
| mem_rdata | input | 8 | Memory read data |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |

## Verification
The hardest behaviour to reach is the per-run open-bus rule in blank-period mode. To see the opcode land at the start of the second block and nowhere else, a run has to park, resume on a pulse, and have its source cross from a fetchable region into a blocked one exactly at a block boundary. Directed cases start a two-block blank-period run at source 0x7FF0 with a low program counter to do this. Further directed cases cover a source aliased from 0xE1xx, a destination that wraps past 0x9FFF, and a full 128-block burst. Seeded random runs cover the remaining combinations of region, speed and mode. While the engine is parked, the bench also writes a register and sends a blank pulse in the middle of a block, and then checks that the byte stream and the stall count are unchanged.

// File: rtl/vdma_pkg.sv
package vdma_pkg;

    localparam int unsigned CNT_W = 7;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PARK = 2'd1,
        ST_LEAD = 2'd2,
        ST_MOVE = 2'd3
    } vdma_state_e;

    localparam logic [2:0] RS_SRC_HI = 3'd0;
    localparam logic [2:0] RS_SRC_LO = 3'd1;
    localparam logic [2:0] RS_DST_HI = 3'd2;
    localparam logic [2:0] RS_DST_LO = 3'd3;
    localparam logic [2:0] RS_CTL    = 3'd4;

    // Regions the engine may fetch from: low 32 KiB, 0xA000-0xDFFF
    function automatic logic src_fetchable(input logic [15:0] a);
        return (a[15] == 1'b0) || (a[15:13] == 3'b101) || (a[15:13] == 3'b110);
    endfunction

    // Sources at 0xE000 and above fold into the 0xF000 page
    function automatic logic [15:0] src_fold(input logic [15:0] a);
        return (a[15:13] == 3'b111) ? {4'hF, a[11:0]} : a;
    endfunction

endpackage

// File: rtl/vdma_src_gate.sv
module vdma_src_gate
    import vdma_pkg::*;
(
    input  logic [15:0] addr,
    input  logic [7:0]  rdata,
    input  logic [7:0]  open_bus,
    output logic        fetch_ok,
    output logic [7:0]  byte_o
);
    assign fetch_ok = src_fetchable(addr);
    assign byte_o   = fetch_ok ? rdata : open_bus;
endmodule

// File: rtl/vdma_byte_pacer.sv
module vdma_byte_pacer #(
    parameter int unsigned NORM_TICKS = 2,
    parameter int unsigned FAST_TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic fast,
    output logic rd_slot,
    output logic wr_slot
);
    localparam int unsigned PH_W = (FAST_TICKS > 2) ? $clog2(FAST_TICKS) : 1;

    logic [PH_W-1:0] ph_q;
    logic [PH_W-1:0] ph_last;

    assign ph_last = fast ? PH_W'(FAST_TICKS - 1) : PH_W'(NORM_TICKS - 1);
    assign rd_slot = run && (ph_q == '0);
    assign wr_slot = run && (ph_q == ph_last);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q <= '0;
        end else if (!run || wr_slot) begin
            ph_q <= '0;
        end else begin
            ph_q <= ph_q + PH_W'(1);
        end
    end
endmodule

// File: rtl/vram_block_dma.sv
module vram_block_dma
    import vdma_pkg::*;
#(
    parameter int unsigned LEAD_TICKS = 4,
    parameter int unsigned NORM_TICKS = 2,
    parameter int unsigned FAST_TICKS = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [2:0]  reg_sel,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  ctl_rdata,
    input  logic        hblank_pulse,
    input  logic        double_speed,
    input  logic [7:0]  cpu_opcode,
    input  logic [15:0] cpu_pc,
    output logic        cpu_stall,
    output logic [15:0] mem_addr,
    output logic        mem_re,
    input  logic [7:0]  mem_rdata,
    output logic        mem_we,
    output logic [7:0]  mem_wdata
);
    localparam int unsigned LEAD_W = $clog2(LEAD_TICKS + 1);

    vdma_state_e state_q, state_d;

    logic [15:0]      src_q;
    logic [12:0]      dst_q;
    logic [CNT_W-1:0] left_q;
    logic             hb_q;
    logic             fast_q;
    logic [7:0]       ob_q;
    logic [7:0]       byte_q;
    logic [LEAD_W-1:0] lead_q;

    logic cfg_ok, start_wr, enter_lead, lead_done;
    logic blk_end, rd_slot, wr_slot, in_move;
    logic fetch_ok;
    logic [7:0] gate_byte;

    assign cfg_ok     = (state_q == ST_IDLE);
    assign start_wr   = reg_we && cfg_ok && (reg_sel == RS_CTL);
    assign enter_lead = (start_wr && !reg_wdata[7]) ||
                        ((state_q == ST_PARK) && hblank_pulse);
    assign lead_done  = (state_q == ST_LEAD) && (lead_q == LEAD_W'(LEAD_TICKS - 1));
    assign in_move    = (state_q == ST_MOVE);
    assign blk_end    = (dst_q[3:0] == 4'hF);

    vdma_byte_pacer #(
        .NORM_TICKS (NORM_TICKS),
        .FAST_TICKS (FAST_TICKS)
    ) u_pacer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (in_move),
        .fast    (fast_q),
        .rd_slot (rd_slot),
        .wr_slot (wr_slot)
    );

    vdma_src_gate u_gate (
        .addr     (src_q),
        .rdata    (mem_rdata),
        .open_bus (ob_q),
        .fetch_ok (fetch_ok),
        .byte_o   (gate_byte)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_wr)     state_d = reg_wdata[7] ? ST_PARK : ST_LEAD;
            ST_PARK: if (hblank_pulse) state_d = ST_LEAD;
            ST_LEAD: if (lead_done)    state_d = ST_MOVE;
            ST_MOVE: begin
                if (wr_slot && blk_end) begin
                    if (left_q == '0) state_d = ST_IDLE;
                    else if (hb_q)    state_d = ST_PARK;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Pointers, counters and byte latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q  <= '0;
            dst_q  <= '0;
            left_q <= '1;
            hb_q   <= 1'b0;
            fast_q <= 1'b0;
            ob_q   <= 8'hFF;
            byte_q <= 8'hFF;
            lead_q <= '0;
        end else begin
            lead_q <= (state_q == ST_LEAD) ? lead_q + LEAD_W'(1) : '0;
            if (reg_we && cfg_ok) begin
                if (reg_sel == RS_SRC_HI) src_q <= src_fold({reg_wdata, src_q[7:0]});
                if (reg_sel == RS_SRC_LO) src_q[7:0] <= {reg_wdata[7:4], 4'h0};
                if (reg_sel == RS_DST_HI) dst_q[12:8] <= reg_wdata[4:0];
                if (reg_sel == RS_DST_LO) dst_q[7:0] <= {reg_wdata[7:4], 4'h0};
                if (reg_sel == RS_CTL) begin
                    left_q <= reg_wdata[CNT_W-1:0];
                    hb_q   <= reg_wdata[7];
                end
            end
            if (enter_lead) begin
                ob_q   <= (cpu_pc > 16'h8000) ? 8'hFF : cpu_opcode;
                fast_q <= double_speed;
            end
            if (in_move && rd_slot) byte_q <= gate_byte;
            if (in_move && wr_slot) begin
                src_q <= src_q + 16'd1;
                dst_q <= dst_q + 13'd1;
                ob_q  <= 8'hFF;
                if (blk_end) left_q <= left_q - CNT_W'(1);
            end
        end
    end

    // Outputs
    always_comb begin
        mem_re    = in_move && rd_slot && fetch_ok;
        mem_we    = in_move && wr_slot;
        mem_addr  = mem_we ? {3'b100, dst_q} : src_q;
        mem_wdata = byte_q;
        cpu_stall = (state_q == ST_LEAD) || in_move;
        ctl_rdata = {(state_q == ST_IDLE), left_q};
    end

endmodule

// File: rtl/vdma_checker.sv
module vdma_checker
    import vdma_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        mem_re,
    input logic        mem_we,
    input logic [15:0] mem_addr,
    input logic        cpu_stall,
    input logic [7:0]  ctl_rdata
);
    AST_WR_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr[15:13] == 3'b100)); // R2
    AST_RD_REGION: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |-> src_fetchable(mem_addr)); // R4
    AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && mem_we)); // R6
    AST_WR_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we); // R6
    AST_RD_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> !mem_re); // R6
    AST_STALL_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> cpu_stall); // R6
    AST_LEAD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_stall) |-> (!mem_re && !mem_we)); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata[7] |-> (!cpu_stall && !mem_re && !mem_we)); // R1
endmodule

bind vram_block_dma vdma_checker u_chk (.*);

// File: tb/vram_block_dma_tb.sv
module vram_block_dma_tb;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  ctl_rdata;
    logic        hblank_pulse = 1'b0;
    logic        double_speed = 1'b0;
    logic [7:0]  cpu_opcode = '0;
    logic [15:0] cpu_pc = '0;
    logic        cpu_stall;
    logic [15:0] mem_addr;
    logic        mem_re;
    logic [7:0]  mem_rdata;
    logic        mem_we;
    logic [7:0]  mem_wdata;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    vram_block_dma u_dut (.*);

    function automatic logic [7:0] src_byte(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
    endfunction

    function automatic bit fetchable(input logic [15:0] a);
        return (a < 16'h8000) || (a >= 16'hA000 && a < 16'hE000);
    endfunction

    assign mem_rdata = src_byte(mem_addr);

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [7:0] v);
        reg_sel = s; reg_wdata = v; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic run_xfer(input logic [7:0] sh, input logic [7:0] sl,
                            input logic [7:0] dh, input logic [7:0] dl,
                            input int blocks, input bit hb, input bit fast,
                            input logic [7:0] op, input logic [15:0] pc);
        logic [15:0] src0, s;
        logic [12:0] dst0, d;
        logic [7:0]  ob, exp_d;
        int idx, stall_cnt, wait_cnt, guard, nb, exp_stall;
        bit first;
        double_speed = fast; cpu_opcode = op; cpu_pc = pc;
        wr(3'd0, sh); wr(3'd1, sl); wr(3'd2, dh); wr(3'd3, dl);
        src0 = {sh, sl[7:4], 4'h0};
        if (src0 >= 16'hE000) src0[15:12] = 4'hF;       // R3
        dst0 = {dh[4:0], dl[7:4], 4'h0};                 // R2
        wr(3'd4, {hb, 7'(blocks - 1)});
        idx = 0; stall_cnt = 0; wait_cnt = 0; guard = 0;
        nb = fast ? 4 : 2;
        while (1) begin
            hblank_pulse = 1'b0;
            reg_we = 1'b0;
            if (mem_we) begin
                s = src0 + 16'(idx);
                d = dst0 + 13'(idx);
                first = hb ? (idx % 16 == 0) : (idx == 0);
                ob = (first && pc <= 16'h8000) ? op : 8'hFF;
                exp_d = fetchable(s) ? src_byte(s) : ob;
                chk(mem_addr == {3'b100, d}, "R2", "write address", mem_addr, {3'b100, d});
                chk(mem_wdata == exp_d, "R4/R5", "write data", mem_wdata, exp_d);
                idx++;
                if (idx % 16 == 5) hblank_pulse = 1'b1;  // R8 ignored mid-block
            end
            if (cpu_stall) stall_cnt++;
            if (ctl_rdata[7]) break;
            if (hb && !cpu_stall && !hblank_pulse) begin
                wait_cnt++;
                if (wait_cnt == 3) begin                 // R10 write while parked
                    reg_sel = 3'd0; reg_wdata = 8'h00; reg_we = 1'b1;
                end
                if (wait_cnt == 6) begin
                    chk(idx % 16 == 0, "R8", "park at block boundary", idx, (idx / 16) * 16);
                    chk(ctl_rdata == {1'b0, 7'(blocks - 1 - idx / 16)}, "R9",
                        "readback while parked", ctl_rdata, {1'b0, 7'(blocks - 1 - idx / 16)});
                    hblank_pulse = 1'b1;
                    wait_cnt = 0;
                end
            end
            guard++;
            if (guard > 40000) begin
                chk(0, "R7", "transfer hung", idx, blocks * 16);
                break;
            end
            @(negedge clk);
        end
        hblank_pulse = 1'b0; reg_we = 1'b0;
        exp_stall = hb ? blocks * (4 + 16 * nb) : 4 + 16 * blocks * nb;
        chk(idx == blocks * 16, "R11", "bytes written", idx, blocks * 16);
        chk(stall_cnt == exp_stall, "R6", "stall cycles", stall_cnt, exp_stall);
        chk(ctl_rdata == 8'hFF, "R9", "readback after completion", ctl_rdata, 8'hFF);
        @(negedge clk);
    endtask

    initial begin
        int seed_dummy;
        bit quiet;
        seed_dummy = $urandom(32'h00C0FFEE);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ctl_rdata == 8'hFF, "R1", "reset readback", ctl_rdata, 8'hFF);
        chk(!cpu_stall && !mem_we && !mem_re, "R1", "reset quiet",
            {cpu_stall, mem_we, mem_re}, 0);
        hblank_pulse = 1'b1;
        @(negedge clk);
        hblank_pulse = 1'b0;
        quiet = 1;
        for (int i = 0; i < 4; i++) begin
            if (cpu_stall || mem_we || mem_re) quiet = 0;
            @(negedge clk);
        end
        chk(quiet, "R1", "blank pulse while idle", !quiet, 0);

        // R7 general mode, slow speed
        run_xfer(8'h12, 8'h3F, 8'h80, 8'h05, 2, 0, 0, 8'h3E, 16'h0150);
        // R3 aliased source, all open bus, fast
        run_xfer(8'hE1, 8'h20, 8'h00, 8'h40, 1, 0, 1, 8'hAA, 16'h0100);
        // R2 destination wrap past 0x9FFF
        run_xfer(8'h40, 8'h00, 8'h9F, 8'hF0, 3, 0, 0, 8'h11, 16'h0100);
        // R5 blank-period mode, source crosses into a blocked region at a block edge
        run_xfer(8'h7F, 8'hF0, 8'h01, 8'h00, 2, 1, 0, 8'h5D, 16'h0200);
        // R5 program counter above 0x8000 gives 0xFF
        run_xfer(8'h90, 8'h00, 8'h02, 8'h00, 1, 0, 0, 8'h77, 16'h9000);
        // R4 cartridge-RAM and work-RAM regions, blank-period mode, fast
        run_xfer(8'hA0, 8'h00, 8'h03, 8'h00, 2, 1, 1, 8'h01, 16'h0300);
        run_xfer(8'hDF, 8'hF0, 8'h04, 8'h00, 2, 0, 1, 8'h02, 16'h0300);
        // R11 full 128-block burst
        run_xfer(8'h00, 8'h00, 8'h00, 8'h00, 128, 0, 0, 8'hC3, 16'h0000);

        for (int t = 0; t < 24; t++) begin
            run_xfer(8'($urandom_range(0, 255)), 8'($urandom_range(0, 255)),
                     8'($urandom_range(0, 255)), 8'($urandom_range(0, 255)),
                     $urandom_range(1, 6), 1'($urandom_range(0, 1)),
                     1'($urandom_range(0, 1)), 8'($urandom_range(0, 255)),
                     16'($urandom_range(0, 65535)));
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog R7 actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule